// File: doc/BRIEF.md
# SIMD Accumulator ALU with Pattern Detector

This block is the second stage of an arithmetic slice. Three 48-bit operands, called X, Y and Z, are picked each cycle by a 7-bit select word from a set of sources. The sources are the external operands A, B and C, the block's own registered result P, all-zeros and all-ones. A carry-in enters from one of several sources. The block adds the operands, or takes Z minus the sum of X, Y and the carry-in, or applies a bitwise function to X and Z. The result is written to the registered output P. Feeding P back as an operand turns the block into an accumulator.

The adder can run as one 48-bit lane, as two independent 24-bit lanes or as four independent 12-bit lanes. Each lane reports its own carry-out, and no carry passes between lanes. A masked comparator checks every new P against a pattern and against the complement of that pattern. From these two matches the block derives overflow and underflow flags. When enabled, a match also clears the accumulator on the next cycle, which gives a terminal-count counter with no extra logic.

With `IN_REG` = 1 (the default), the control inputs and the operands pass through one input register before the arithmetic. A result therefore appears on `p_o` after the second rising edge that follows the cycle in which its inputs were presented.

Top module: `simd_alu48`

## Requirements
- R1: While `rst_ni` is low, `p_o`, `carry_o`, `pat_det_o`, `pat_detb_o`, `overflow_o` and `underflow_o` are all zero.
- R2: The field `opmode_i[1:0]` selects X: 00 zero, 01 P, 10 A, 11 all-ones. The field `opmode_i[3:2]` selects Y: 00 zero, 01 all-ones, 10 C, 11 B. The field `opmode_i[6:4]` selects Z: 001 P, 010 C, 011 B, and any other code gives zero.
- R3: With `alu_mode_i` = 0x0, each lane computes Z+X+Y+cin modulo 2^lane-width. The lane's carry-out is 1 when the true sum reaches 2^lane-width.
- R4: With `alu_mode_i` = 0x3, each lane computes Z−(X+Y+cin) modulo 2^lane-width. The lane's carry-out is 1 exactly when Z ≥ X+Y+cin, taken as unsigned lane values. All other codes from 0x0 to 0x7 act as addition.
- R5: The input `lane_mode_i` selects the lane split: 00 or 11 gives one 48-bit lane, 01 gives two 24-bit lanes, 10 gives four 12-bit lanes. No carry crosses a lane boundary, and the carry-in enters only the lowest lane. The outputs `carry_o[i]` report lane i in the four-lane split. The two-lane split uses `carry_o[1]` for the low lane and `carry_o[3]` for the high lane, and the single lane uses `carry_o[3]`. Unused bits read 0.
- R6: The `alu_mode_i` codes 0x8 to 0xF select the logic unit acting on X and Z: 0x8 AND, 0x9 OR, 0xA XOR, 0xB XNOR, 0xC NAND, 0xD NOR, 0xE NOT Z, 0xF pass Z. In these modes `carry_o` is 0.
- R7: The input `carry_sel_i` picks the carry-in: 000 takes `carry_i`, 001 takes the `carry_o[3]` of the current cycle, 010 takes the inverted sign bit of P (for rounding), and any other code gives 0.
- R8: With `IN_REG` = 1, an operation presented before rising edge k updates `p_o` and `carry_o` at rising edge k+1.
- R9: The flags `pat_det_o` and `pat_detb_o` are registered together with P. `pat_det_o` is 1 when every bit of P whose mask bit is 0 equals the corresponding bit of `pattern_i`. `pat_detb_o` is the same test against the inverted pattern.
- R10: `overflow_o` rises when `pat_det_o` was 1 in the previous cycle and the new P matches neither the pattern nor its complement. `underflow_o` follows the same rule using `pat_detb_o`.
- R11: When `auto_rst_i` is active in the stage and `pat_det_o` is 1, the next P is zero, `carry_o` is zero, and the overflow and underflow flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opmode_i | input | 7 | Selects for X, Y and Z |
| alu_mode_i | input | 4 | Arithmetic or logic function |
| lane_mode_i | input | 2 | Lane split: 1, 2 or 4 lanes |
| carry_sel_i | input | 3 | Carry-in source |
| carry_i | input | 1 | External carry-in |
| auto_rst_i | input | 1 | Enable clear-on-match |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| c_i | input | W | Operand C |
| pattern_i | input | W | Pattern compared against P |
| mask_i | input | W | Mask bits; 1 ignores the bit |
| p_o | output | W | Registered result |
| carry_o | output | 4 | Per-lane carry-out |
| pat_det_o | output | 1 | P matches the pattern |
| pat_detb_o | output | 1 | P matches the inverted pattern |
| overflow_o | output | 1 | Match lost going up |
| underflow_o | output | 1 | Complement match lost |

## Verification
Some properties are checked on every cycle. Each lane split must leave its unused carry bits at zero, and logic modes must produce no carry. A clear-on-match must zero P and both flags on the following cycle. Overflow and underflow may only be raised after a match in the previous cycle and with no match in the current one. The arithmetic values themselves can only be shown by the bench's scenarios. These cover the absence of carry between lanes, the carry-in reaching only the lowest lane, subtraction borrow, the operand-select decoding, chaining the carry across cycles, sign-based rounding, and counting sequences up to a terminal count in both directions.

// File: rtl/simd_alu48_pkg.sv
package simd_alu48_pkg;

  typedef enum logic [1:0] {
    LANES_1    = 2'b00,
    LANES_2    = 2'b01,
    LANES_4    = 2'b10,
    LANES_RSVD = 2'b11
  } lane_mode_e;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h3;
  localparam logic [3:0] OP_AND  = 4'h8;
  localparam logic [3:0] OP_OR   = 4'h9;
  localparam logic [3:0] OP_XOR  = 4'hA;
  localparam logic [3:0] OP_XNOR = 4'hB;
  localparam logic [3:0] OP_NAND = 4'hC;
  localparam logic [3:0] OP_NOR  = 4'hD;
  localparam logic [3:0] OP_NOT  = 4'hE;

  localparam int unsigned MAX_LANES = 4;

  typedef struct packed {
    logic [6:0] opmode;
    logic [3:0] alu;
    lane_mode_e lanes;
    logic [2:0] csel;
    logic       cin;
    logic       autorst;
  } ctrl_t;

endpackage

// File: rtl/lane_addsub.sv
module lane_addsub #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  // two guard bits hold a three-operand sum or a negative difference
  logic [W+1:0] xy, t;

  always_comb begin
    xy = {2'b00, x_i} + {2'b00, y_i} + {{(W+1){1'b0}}, cin_i};
    t  = sub_i ? ({2'b00, z_i} - xy) : ({2'b00, z_i} + xy);
    sum_o  = t[W-1:0];
    cout_o = sub_i ? ~t[W+1] : |t[W+1:W];
  end
endmodule

// File: rtl/logic_unit.sv
module logic_unit
  import simd_alu48_pkg::*;
#(
  parameter int unsigned W = 48
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] z_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] r_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  r_o = x_i & z_i;
      OP_OR:   r_o = x_i | z_i;
      OP_XOR:  r_o = x_i ^ z_i;
      OP_XNOR: r_o = x_i ~^ z_i;
      OP_NAND: r_o = ~(x_i & z_i);
      OP_NOR:  r_o = ~(x_i | z_i);
      OP_NOT:  r_o = ~z_i;
      default: r_o = z_i;
    endcase
  end
endmodule

// File: rtl/pat_match.sv
module pat_match #(
  parameter int unsigned W = 48
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] pattern_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o,
  output logic         hit_b_o
);
  always_comb begin
    hit_o   = &((p_i ~^ pattern_i) | mask_i);
    hit_b_o = &((p_i ^ pattern_i) | mask_i);
  end
endmodule

// File: rtl/simd_alu48.sv
module simd_alu48
  import simd_alu48_pkg::*;
#(
  parameter int unsigned W      = 48,
  parameter bit          IN_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [6:0]   opmode_i,
  input  logic [3:0]   alu_mode_i,
  input  logic [1:0]   lane_mode_i,
  input  logic [2:0]   carry_sel_i,
  input  logic         carry_i,
  input  logic         auto_rst_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] pattern_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] p_o,
  output logic [3:0]   carry_o,
  output logic         pat_det_o,
  output logic         pat_detb_o,
  output logic         overflow_o,
  output logic         underflow_o
);
  localparam int unsigned W2 = W / 2;
  localparam int unsigned W4 = W / 4;

  ctrl_t        ctrl_in, st_ctrl;
  logic [W-1:0] st_a, st_b, st_c, st_pat, st_mask;

  assign ctrl_in = '{opmode: opmode_i, alu: alu_mode_i,
                     lanes: lane_mode_e'(lane_mode_i), csel: carry_sel_i,
                     cin: carry_i, autorst: auto_rst_i};

  generate
    if (IN_REG) begin : g_inreg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          st_ctrl <= '0;
          st_a    <= '0;
          st_b    <= '0;
          st_c    <= '0;
          st_pat  <= '0;
          st_mask <= '0;
        end else begin
          st_ctrl <= ctrl_in;
          st_a    <= a_i;
          st_b    <= b_i;
          st_c    <= c_i;
          st_pat  <= pattern_i;
          st_mask <= mask_i;
        end
      end
    end else begin : g_direct
      always_comb begin
        st_ctrl = ctrl_in;
        st_a    = a_i;
        st_b    = b_i;
        st_c    = c_i;
        st_pat  = pattern_i;
        st_mask = mask_i;
      end
    end
  endgenerate

  logic [W-1:0] p_q;
  logic [3:0]   c_q;
  logic         det_q, detb_q, ovf_q, unf_q;

  // operand selection
  logic [W-1:0] x_v, y_v, z_v;
  logic         cin_v;

  always_comb begin
    unique case (st_ctrl.opmode[1:0])
      2'b00:   x_v = '0;
      2'b01:   x_v = p_q;
      2'b10:   x_v = st_a;
      default: x_v = '1;
    endcase
    unique case (st_ctrl.opmode[3:2])
      2'b00:   y_v = '0;
      2'b01:   y_v = '1;
      2'b10:   y_v = st_c;
      default: y_v = st_b;
    endcase
    case (st_ctrl.opmode[6:4])
      3'b001:  z_v = p_q;
      3'b010:  z_v = st_c;
      3'b011:  z_v = st_b;
      default: z_v = '0;
    endcase
    case (st_ctrl.csel)
      3'b000:  cin_v = st_ctrl.cin;
      3'b001:  cin_v = c_q[3];
      3'b010:  cin_v = ~p_q[W-1];
      default: cin_v = 1'b0;
    endcase
  end

  logic sub_v, logic_s, autorst_s;
  lane_mode_e lanes_s;
  assign sub_v     = (st_ctrl.alu == OP_SUB);
  assign logic_s   = st_ctrl.alu[3];
  assign autorst_s = st_ctrl.autorst;
  assign lanes_s   = st_ctrl.lanes;

  // one adder set per lane split; carry-in only into the lowest lane
  logic [W-1:0] s_full, s_half, s_quar;
  logic         c_full;
  logic [1:0]   c_half;
  logic [3:0]   c_quar;

  lane_addsub #(.W(W)) u_full (
    .x_i(x_v), .y_i(y_v), .z_i(z_v), .cin_i(cin_v), .sub_i(sub_v),
    .sum_o(s_full), .cout_o(c_full)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    lane_addsub #(.W(W2)) u_add (
      .x_i(x_v[g*W2 +: W2]), .y_i(y_v[g*W2 +: W2]), .z_i(z_v[g*W2 +: W2]),
      .cin_i((g == 0) ? cin_v : 1'b0), .sub_i(sub_v),
      .sum_o(s_half[g*W2 +: W2]), .cout_o(c_half[g])
    );
  end

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_quar
    lane_addsub #(.W(W4)) u_add (
      .x_i(x_v[g*W4 +: W4]), .y_i(y_v[g*W4 +: W4]), .z_i(z_v[g*W4 +: W4]),
      .cin_i((g == 0) ? cin_v : 1'b0), .sub_i(sub_v),
      .sum_o(s_quar[g*W4 +: W4]), .cout_o(c_quar[g])
    );
  end

  logic [W-1:0] lres;
  logic_unit #(.W(W)) u_logic (
    .x_i(x_v), .z_i(z_v), .op_i(st_ctrl.alu), .r_o(lres)
  );

  logic [W-1:0] sum_v, p_nxt;
  logic [3:0]   cv, c_nxt;
  logic         clr_v;

  always_comb begin
    unique case (lanes_s)
      LANES_2: begin sum_v = s_half; cv = {c_half[1], 1'b0, c_half[0], 1'b0}; end
      LANES_4: begin sum_v = s_quar; cv = c_quar; end
      default: begin sum_v = s_full; cv = {c_full, 3'b000}; end
    endcase
    clr_v = autorst_s & det_q;
    p_nxt = clr_v ? '0 : (logic_s ? lres : sum_v);
    c_nxt = (clr_v | logic_s) ? 4'b0000 : cv;
  end

  logic hit_v, hitb_v;
  pat_match #(.W(W)) u_pat (
    .p_i(p_nxt), .pattern_i(st_pat), .mask_i(st_mask),
    .hit_o(hit_v), .hit_b_o(hitb_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q    <= '0;
      c_q    <= '0;
      det_q  <= 1'b0;
      detb_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      p_q    <= p_nxt;
      c_q    <= c_nxt;
      det_q  <= hit_v;
      detb_q <= hitb_v;
      ovf_q  <= ~clr_v & det_q  & ~hit_v & ~hitb_v;
      unf_q  <= ~clr_v & detb_q & ~hit_v & ~hitb_v;
    end
  end

  assign p_o         = p_q;
  assign carry_o     = c_q;
  assign pat_det_o   = det_q;
  assign pat_detb_o  = detb_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

endmodule

// File: rtl/simd_alu48_chk.sv
module simd_alu48_chk
  import simd_alu48_pkg::*;
#(
  parameter int unsigned W = 48
) (
  input logic         clk_i,
  input logic         rst_ni,
  input lane_mode_e   lanes_i,
  input logic         logic_i,
  input logic         autorst_i,
  input logic [W-1:0] p_o,
  input logic [3:0]   carry_o,
  input logic         pat_det_o,
  input logic         pat_detb_o,
  input logic         overflow_o,
  input logic         underflow_o
);
  // R5
  one_lane_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lanes_i != LANES_2 && lanes_i != LANES_4) |=> carry_o[2:0] == 3'b000);

  // R5
  two_lane_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lanes_i == LANES_2) |=> (carry_o[0] == 1'b0 && carry_o[2] == 1'b0));

  // R6
  logic_no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_i |=> carry_o == 4'b0000);

  // R11
  auto_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_det_o && autorst_i) |=> (p_o == '0 && !overflow_o && !underflow_o));

  // R10
  overflow_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> ($past(pat_det_o) && !pat_det_o && !pat_detb_o));

  // R10
  underflow_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> ($past(pat_detb_o) && !pat_det_o && !pat_detb_o));
endmodule

bind simd_alu48 simd_alu48_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lanes_i(lanes_s), .logic_i(logic_s),
  .autorst_i(autorst_s), .p_o(p_o), .carry_o(carry_o),
  .pat_det_o(pat_det_o), .pat_detb_o(pat_detb_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o)
);

// File: tb/simd_alu48_tb_top.sv
module simd_alu48_tb_top;
  localparam time CLK_P = 10ns;
  localparam int  NV    = 17;
  localparam logic [47:0] LOW4 = 48'hFFFF_FFFF_FFF0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  opmode_i = '0;
  logic [3:0]  alu_mode_i = '0;
  logic [1:0]  lane_mode_i = '0;
  logic [2:0]  carry_sel_i = '0;
  logic        carry_i = 1'b0;
  logic        auto_rst_i = 1'b0;
  logic [47:0] a_i = '0, b_i = '0, c_i = '0, pattern_i = '0, mask_i = '0;
  logic [47:0] p_o;
  logic [3:0]  carry_o;
  logic        pat_det_o, pat_detb_o, overflow_o, underflow_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  simd_alu48 dut_i (
    .clk_i, .rst_ni, .opmode_i, .alu_mode_i, .lane_mode_i, .carry_sel_i,
    .carry_i, .auto_rst_i, .a_i, .b_i, .c_i, .pattern_i, .mask_i,
    .p_o, .carry_o, .pat_det_o, .pat_detb_o, .overflow_o, .underflow_o
  );

  typedef struct packed {
    logic [6:0]  op;
    logic [3:0]  alu;
    logic [1:0]  lanes;
    logic        cin;
    logic [47:0] a, b, c, p;
    logic [3:0]  co;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{7'b0101110, 4'h0, 2'b00, 1'b1, 48'h10, 48'h20, 48'h5, 48'h36, 4'b0000},                        // R3
    '{7'b0100010, 4'h0, 2'b00, 1'b0, 48'hFFFF_FFFF_FFFF, 48'h0, 48'h2, 48'h1, 4'b1000},              // R3
    '{7'b0100010, 4'h0, 2'b01, 1'b0, 48'h000001_FFFFFF, 48'h0, 48'h000002_000001, 48'h000003_000000, 4'b0010}, // R5
    '{7'b0100010, 4'h0, 2'b10, 1'b0, 48'hFFF_001_800_123, 48'h0, 48'h001_FFF_800_001, 48'h000_000_000_124, 4'b1110}, // R5
    '{7'b0101110, 4'h3, 2'b00, 1'b1, 48'h10, 48'h20, 48'h100, 48'hCF, 4'b1000},                      // R4
    '{7'b0100010, 4'h3, 2'b00, 1'b0, 48'h6, 48'h0, 48'h5, 48'hFFFF_FFFF_FFFF, 4'b0000},              // R4
    '{7'b0100010, 4'h3, 2'b10, 1'b1, 48'h001_001_001_001, 48'h0, 48'h000_005_000_003, 48'hFFF_004_FFF_001, 4'b0101}, // R5
    '{7'b0100010, 4'h8, 2'b00, 1'b0, 48'hF0F0_F0F0_F0F0, 48'h0, 48'h0FF0_0FF0_0FF0, 48'h00F0_00F0_00F0, 4'b0000}, // R6
    '{7'b0100010, 4'h9, 2'b00, 1'b0, 48'hF0F0_F0F0_F0F0, 48'h0, 48'h0FF0_0FF0_0FF0, 48'hFFF0_FFF0_FFF0, 4'b0000}, // R6
    '{7'b0100010, 4'hA, 2'b10, 1'b0, 48'hF0F0_F0F0_F0F0, 48'h0, 48'h0FF0_0FF0_0FF0, 48'hFF00_FF00_FF00, 4'b0000}, // R6
    '{7'b0100010, 4'hB, 2'b00, 1'b0, 48'hF0F0_F0F0_F0F0, 48'h0, 48'h0FF0_0FF0_0FF0, 48'h00FF_00FF_00FF, 4'b0000}, // R6
    '{7'b0100010, 4'hC, 2'b00, 1'b0, 48'hF0F0_F0F0_F0F0, 48'h0, 48'h0FF0_0FF0_0FF0, 48'hFF0F_FF0F_FF0F, 4'b0000}, // R6
    '{7'b0100010, 4'hD, 2'b00, 1'b0, 48'hF0F0_F0F0_F0F0, 48'h0, 48'h0FF0_0FF0_0FF0, 48'h000F_000F_000F, 4'b0000}, // R6
    '{7'b0100010, 4'hE, 2'b00, 1'b0, 48'hF0F0_F0F0_F0F0, 48'h0, 48'h0FF0_0FF0_0FF0, 48'hF00F_F00F_F00F, 4'b0000}, // R6
    '{7'b0100100, 4'h0, 2'b00, 1'b0, 48'h0, 48'h0, 48'h5, 48'h4, 4'b1000},                           // R2
    '{7'b0110000, 4'h0, 2'b00, 1'b0, 48'h0, 48'h77, 48'h0, 48'h77, 4'b0000},                         // R2
    '{7'b0001011, 4'h0, 2'b00, 1'b0, 48'h0, 48'h0, 48'h3, 48'h2, 4'b1000}                            // R2
  };

  function automatic string row_tag(input int i);
    if (i < 2) return "R3";
    if (i < 4) return "R5";
    if (i < 6) return "R4";
    if (i < 7) return "R5";
    if (i < 14) return "R6";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic set_in(input logic [6:0] op, input logic [3:0] alu, input logic [1:0] ln,
                        input logic [2:0] cs, input logic cin, input logic ar,
                        input logic [47:0] a, input logic [47:0] b, input logic [47:0] c,
                        input logic [47:0] pat, input logic [47:0] msk);
    opmode_i = op; alu_mode_i = alu; lane_mode_i = ln; carry_sel_i = cs;
    carry_i = cin; auto_rst_i = ar; a_i = a; b_i = b; c_i = c;
    pattern_i = pat; mask_i = msk;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    set_in('0, '0, '0, '0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: state held at zero during reset despite active inputs
    set_in(7'b0100010, 4'h0, 2'b00, 3'b000, 1'b1, 1'b0, 48'h123, '0, 48'h5, '0, '1);
    repeat (3) @(negedge clk_i);
    check("R1 p", p_o, '0);
    check("R1 flags", {carry_o, pat_det_o, pat_detb_o, overflow_o, underflow_o}, '0);

    do_reset();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      set_in(VECS[i].op, VECS[i].alu, VECS[i].lanes, 3'b000, VECS[i].cin, 1'b0,
             VECS[i].a, VECS[i].b, VECS[i].c, '0, '1);
      repeat (2) @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("%s row%0d p", row_tag(i), i), p_o, VECS[i].p);
      check($sformatf("%s row%0d carry", row_tag(i), i), {44'h0, carry_o}, {44'h0, VECS[i].co});
    end

    // R11: count up to 3, auto clear
    do_reset();
    set_in(7'b0010000, 4'h0, 2'b00, 3'b000, 1'b1, 1'b0, '0, '0, '0, 48'h3, LOW4);
    for (int e = 1; e <= 6; e++) begin
      @(negedge clk_i);
      if (e == 1) auto_rst_i = 1'b1;
      case (e)
        1: check("R11 e1 p", p_o, 48'h0);
        2: check("R11 e2 p", p_o, 48'h1);
        3: check("R11 e3 p", p_o, 48'h2);
        4: begin
             check("R9 det at 3", {47'h0, pat_det_o}, 48'h1);
             check("R9 detb at 3", {47'h0, pat_detb_o}, 48'h0);
           end
        5: begin
             check("R11 cleared p", p_o, 48'h0);
             check("R11 no ovf", {47'h0, overflow_o}, 48'h0);
           end
        default: check("R11 e6 p", p_o, 48'h1);
      endcase
    end

    // R10: overflow without auto clear
    do_reset();
    set_in(7'b0010000, 4'h0, 2'b00, 3'b000, 1'b1, 1'b0, '0, '0, '0, 48'h3, LOW4);
    for (int e = 1; e <= 5; e++) begin
      @(negedge clk_i);
      if (e == 4) check("R10 no ovf yet", {47'h0, overflow_o}, 48'h0);
      if (e == 5) begin
        check("R10 p past tc", p_o, 48'h4);
        check("R10 ovf", {47'h0, overflow_o}, 48'h1);
        check("R10 no unf", {47'h0, underflow_o}, 48'h0);
      end
    end

    // R10: underflow counting down
    do_reset();
    set_in(7'b0010000, 4'h3, 2'b00, 3'b000, 1'b1, 1'b0, '0, '0, '0, 48'h3, LOW4);
    for (int e = 1; e <= 6; e++) begin
      @(negedge clk_i);
      if (e == 5) check("R9 detb", {47'h0, pat_detb_o}, 48'h1);
      if (e == 6) begin
        check("R4 down p", p_o, 48'hFFFF_FFFF_FFFB);
        check("R10 unf", {47'h0, underflow_o}, 48'h1);
      end
    end

    // R7 / R8: carry chained across cycles, then sign rounding
    do_reset();
    set_in(7'b0100010, 4'h0, 2'b00, 3'b000, 1'b0, 1'b0, 48'hFFFF_FFFF_FFFF, '0, 48'h1, '0, '1);
    @(negedge clk_i);
    check("R8 one edge carry", {44'h0, carry_o}, 48'h0);
    set_in(7'b0000010, 4'h0, 2'b00, 3'b001, 1'b0, 1'b0, 48'h5, '0, '0, '0, '1);
    @(negedge clk_i);
    check("R8 two edge p", p_o, 48'h0);
    check("R8 two edge carry", {44'h0, carry_o}, 48'h8);
    set_in(7'b0010000, 4'h0, 2'b00, 3'b010, 1'b0, 1'b0, '0, '0, '0, '0, '1);
    @(negedge clk_i);
    check("R7 prior carry", p_o, 48'h6);
    @(negedge clk_i);
    check("R7 sign round", p_o, 48'h7);

    // R1: asynchronous clear
    rst_ni = 1'b0;
    #1;
    check("R1 async p", p_o, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule